// File: doc/BRIEF.md
# Selectable ALU Term Generator

This block builds one term of a series from two operands. The first operand is the product of a 3-bit scale factor and a 10-bit base value. The second operand is a small offset, widened with zeros. A function code and a mode code together choose one entry of the classic 4-bit-slice ALU function table. That entry is applied across the full product width.

The result is then checked for zero. A zero result is replaced by one, because the next stage divides by the term and must never see a zero divisor. The block is purely combinational. It sits between the operand registers of a digit engine and the divider that uses the term.

Top module: `term_gen`

## Requirements
- R1: The product operand P equals gamma_i × b_i as a full 13-bit unsigned product. With row_i=15 and col_i=0 the output equals P, or 1 when P is 0.
- R2: The offset operand Q is alpha_i zero-extended to 13 bits. With row_i=10 and col_i=0 the output equals Q, or 1 when Q is 0.
- R3: col_i picks the mode. 0 selects bitwise logic. 1 selects arithmetic with no carry-in. 2 selects arithmetic with carry-in, which adds 1 to the col_i=1 result. 3 behaves exactly like 0.
- R4: The logic results, indexed by row_i, are:
  - 0: ~P
  - 1: ~(P|Q)
  - 2: ~P&Q
  - 3: 0
  - 4: ~(P&Q)
  - 5: ~Q
  - 6: P^Q
  - 7: P&~Q
  - 8: ~P|Q
  - 9: ~(P^Q)
  - 10: Q
  - 11: P&Q
  - 12: all ones
  - 13: P|~Q
  - 14: P|Q
  - 15: P
- R5: The arithmetic results with no carry-in, indexed by row_i, are:
  - 0: P
  - 1: P|Q
  - 2: P|~Q
  - 3: all ones
  - 4: P+(P&~Q)
  - 5: (P|Q)+(P&~Q)
  - 6: P−Q−1
  - 7: (P&~Q)−1
  - 8: P+(P&Q)
  - 9: P+Q
  - 10: (P|~Q)+(P&Q)
  - 11: (P&Q)−1
  - 12: P+P
  - 13: (P|Q)+P
  - 14: (P|~Q)+P
  - 15: P−1
- R6: Four entries act as named operations. row_i=6 with col_i=2 gives P−Q. row_i=9 with col_i=1 gives P+Q. row_i=6 with col_i=0 gives P XOR Q. row_i=11 with col_i=0 gives P AND Q.
- R7: All arithmetic wraps modulo 2^13.
- R8: A function result of zero is output as 1, so g_o is never zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gamma_i | input | 3 | Scale factor for the product operand |
| b_i | input | 10 | Base value for the product operand |
| alpha_i | input | 10 | Offset operand |
| row_i | input | 4 | Function code, the ALU table row |
| col_i | input | 2 | Mode code, the ALU table column |
| g_o | output | 13 | Selected term, never zero |

## Verification
The embedded assertions check three things whenever the inputs settle:
- The output is never zero.
- The output follows the raw function result except when that result is zero.
- The four named entries (subtract, add, XOR, AND) match their plain arithmetic or logic meaning.

The remaining behaviour can only be shown by the bench's scenarios:
- the product forming at its extreme values
- wraparound at 2^13
- column 3 acting as column 0
- the full 64-entry selector space compared against an independent table model over several operand sets

// File: rtl/term_gen_pkg.sv
package term_gen_pkg;
  typedef enum logic [1:0] {
    MODE_LOGIC    = 2'd0,
    MODE_ARITH    = 2'd1,
    MODE_ARITH_CI = 2'd2
  } alu_mode_e;
endpackage

// File: rtl/term_mul.sv
module term_mul #(
  parameter int unsigned GAMMA_W = 3,
  parameter int unsigned BASE_W  = 10,
  localparam int unsigned PROD_W = GAMMA_W + BASE_W
) (
  input  logic [GAMMA_W-1:0] gamma_i,
  input  logic [BASE_W-1:0]  base_i,
  output logic [PROD_W-1:0]  prod_o
);
  logic [PROD_W-1:0] pp [GAMMA_W];

  // one shifted partial product per scale bit
  for (genvar i = 0; i < GAMMA_W; i++) begin : g_pp
    assign pp[i] = gamma_i[i] ? (PROD_W'(base_i) << i) : '0;
  end

  always_comb begin
    prod_o = '0;
    for (int i = 0; i < GAMMA_W; i++) prod_o = prod_o + pp[i];
  end
endmodule

// File: rtl/term_sel_dec.sv
module term_sel_dec
  import term_gen_pkg::*;
(
  input  logic [1:0] col_i,
  output alu_mode_e  mode_o
);
  always_comb begin
    unique case (col_i)
      2'd1:    mode_o = MODE_ARITH;
      2'd2:    mode_o = MODE_ARITH_CI;
      default: mode_o = MODE_LOGIC;  // column 3 folds onto column 0
    endcase
  end
endmodule

// File: rtl/term_alu.sv
module term_alu
  import term_gen_pkg::*;
#(
  parameter int unsigned W = 13
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   fn_i,
  input  alu_mode_e    mode_i,
  output logic [W-1:0] f_o
);
  logic [W-1:0] t_or, t_and;
  logic         ci;

  // generate/propagate style terms; sum of the two is the arithmetic core
  assign t_or  = a_i | ({W{fn_i[0]}} & b_i) | ({W{fn_i[1]}} & ~b_i);
  assign t_and = ({W{fn_i[2]}} & a_i & ~b_i) | ({W{fn_i[3]}} & a_i & b_i);
  assign ci    = (mode_i == MODE_ARITH_CI);

  always_comb begin
    if (mode_i == MODE_LOGIC) f_o = ~(t_or ^ t_and);
    else                      f_o = t_or + t_and + W'(ci);
  end

  always_comb begin
    if (mode_i == MODE_ARITH_CI && fn_i == 4'd6) begin
      // R6
      sub_chk: assert (f_o == a_i - b_i);
    end
    if (mode_i == MODE_ARITH && fn_i == 4'd9) begin
      // R6
      add_chk: assert (f_o == a_i + b_i);
    end
    if (mode_i == MODE_LOGIC && fn_i == 4'd6) begin
      // R6
      xor_chk: assert (f_o == (a_i ^ b_i));
    end
    if (mode_i == MODE_LOGIC && fn_i == 4'd11) begin
      // R6
      and_chk: assert (f_o == (a_i & b_i));
    end
  end
endmodule

// File: rtl/term_nz.sv
module term_nz #(
  parameter int unsigned W = 13
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  assign q_o = (d_i == '0) ? W'(1) : d_i;
endmodule

// File: rtl/term_gen.sv
module term_gen
  import term_gen_pkg::*;
#(
  parameter int unsigned GAMMA_W = 3,
  parameter int unsigned BASE_W  = 10,
  parameter int unsigned ALPHA_W = 10,
  localparam int unsigned WORD_W = GAMMA_W + BASE_W
) (
  input  logic [GAMMA_W-1:0] gamma_i,
  input  logic [BASE_W-1:0]  b_i,
  input  logic [ALPHA_W-1:0] alpha_i,
  input  logic [3:0]         row_i,
  input  logic [1:0]         col_i,
  output logic [WORD_W-1:0]  g_o
);
  logic [WORD_W-1:0] prod, offs, alu_res;
  alu_mode_e         mode;

  assign offs = WORD_W'(alpha_i);

  term_mul #(.GAMMA_W(GAMMA_W), .BASE_W(BASE_W)) u_mul (
    .gamma_i(gamma_i),
    .base_i (b_i),
    .prod_o (prod)
  );

  term_sel_dec u_dec (
    .col_i (col_i),
    .mode_o(mode)
  );

  term_alu #(.W(WORD_W)) u_alu (
    .a_i   (prod),
    .b_i   (offs),
    .fn_i  (row_i),
    .mode_i(mode),
    .f_o   (alu_res)
  );

  term_nz #(.W(WORD_W)) u_nz (
    .d_i(alu_res),
    .q_o(g_o)
  );

  always_comb begin
    // R8
    g_nonzero_chk: assert (g_o != '0);
    if (alu_res != '0) begin
      // R8
      g_pass_chk: assert (g_o == alu_res);
    end else begin
      // R8
      g_one_chk: assert (g_o == WORD_W'(1));
    end
  end
endmodule

// File: tb/term_gen_bench.sv
module term_gen_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  gamma;
  logic [9:0]  bv;
  logic [9:0]  alpha;
  logic [3:0]  row;
  logic [1:0]  col;
  logic [12:0] g;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  term_gen u_term_gen (
    .gamma_i(gamma), .b_i(bv), .alpha_i(alpha),
    .row_i(row), .col_i(col), .g_o(g)
  );

  // {gamma, b, alpha, row, col, expected}
  localparam int NV = 15;
  localparam logic [41:0] VEC [NV] = '{
    {3'd2, 10'd10,   10'd1,    4'd6,  2'd2, 13'h0013},
    {3'd1, 10'd10,   10'd1,    4'd6,  2'd0, 13'h000B},
    {3'd1, 10'd5,    10'd1,    4'd1,  2'd1, 13'h0005},
    {3'd1, 10'd10,   10'd15,   4'd11, 2'd0, 13'h000A},
    {3'd1, 10'd10,   10'd1,    4'd9,  2'd1, 13'h000B},
    {3'd1, 10'd5,    10'd5,    4'd6,  2'd2, 13'h0001},
    {3'd7, 10'd1023, 10'd0,    4'd12, 2'd1, 13'h17F2},
    {3'd1, 10'd10,   10'd1,    4'd6,  2'd3, 13'h000B},
    {3'd1, 10'd10,   10'd1,    4'd3,  2'd0, 13'h0001},
    {3'd0, 10'd0,    10'd0,    4'd6,  2'd1, 13'h1FFF},
    {3'd3, 10'd100,  10'd0,    4'd15, 2'd2, 13'h012C},
    {3'd0, 10'd0,    10'd0,    4'd0,  2'd0, 13'h1FFF},
    {3'd7, 10'd1023, 10'd0,    4'd15, 2'd0, 13'h1BF9},
    {3'd7, 10'd1023, 10'd1023, 4'd10, 2'd0, 13'h03FF},
    {3'd2, 10'd3,    10'd9,    4'd3,  2'd2, 13'h0001}
  };
  localparam string TAG [NV] = '{
    "R6", "R6", "R5", "R6", "R6", "R8", "R7", "R3",
    "R8", "R5", "R3", "R4", "R1", "R2", "R7"
  };

  function automatic logic [12:0] model(input logic [12:0] p, input logic [12:0] q,
                                        input logic [3:0] r, input logic [1:0] c);
    logic [12:0] f;
    if (c == 2'd1 || c == 2'd2) begin
      case (r)
        4'd0:  f = p;
        4'd1:  f = p | q;
        4'd2:  f = p | ~q;
        4'd3:  f = '1;
        4'd4:  f = p + (p & ~q);
        4'd5:  f = (p | q) + (p & ~q);
        4'd6:  f = p - q - 13'd1;
        4'd7:  f = (p & ~q) - 13'd1;
        4'd8:  f = p + (p & q);
        4'd9:  f = p + q;
        4'd10: f = (p | ~q) + (p & q);
        4'd11: f = (p & q) - 13'd1;
        4'd12: f = p + p;
        4'd13: f = (p | q) + p;
        4'd14: f = (p | ~q) + p;
        default: f = p - 13'd1;
      endcase
      if (c == 2'd2) f = f + 13'd1;
    end else begin
      case (r)
        4'd0:  f = ~p;
        4'd1:  f = ~(p | q);
        4'd2:  f = ~p & q;
        4'd3:  f = '0;
        4'd4:  f = ~(p & q);
        4'd5:  f = ~q;
        4'd6:  f = p ^ q;
        4'd7:  f = p & ~q;
        4'd8:  f = ~p | q;
        4'd9:  f = ~(p ^ q);
        4'd10: f = q;
        4'd11: f = p & q;
        4'd12: f = '1;
        4'd13: f = p | ~q;
        4'd14: f = p | q;
        default: f = p;
      endcase
    end
    if (f == '0) f = 13'd1;
    return f;
  endfunction

  task automatic apply(input logic [2:0] ga, input logic [9:0] bb, input logic [9:0] al,
                       input logic [3:0] r, input logic [1:0] c);
    @(posedge clk);
    gamma = ga; bv = bb; alpha = al; row = r; col = c;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [12:0] exp);
    n_chk++;
    if (g !== exp) begin
      n_fail++;
      $display("FAIL %s: gamma=%0d b=%0d alpha=%0d row=%0d col=%0d got %h expected %h",
               tag, gamma, bv, alpha, row, col, g, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    gamma = '0; bv = '0; alpha = '0; row = '0; col = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // idle state: all-zero inputs give ~0 in logic row 0 (R4)
    @(negedge clk);
    check("R4", 13'h1FFF);

    // directed vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][41:39], VEC[i][38:29], VEC[i][28:19], VEC[i][18:15], VEC[i][14:13]);
      check(TAG[i], VEC[i][12:0]);
    end

    // full selector sweep against the model: R4 logic, R5 arithmetic, R3 column 3
    for (int s = 0; s < 4; s++) begin
      logic [2:0] ga;
      logic [9:0] bb, al;
      case (s)
        0: begin ga = 3'd1; bb = 10'd10;   al = 10'd1;    end
        1: begin ga = 3'd7; bb = 10'd1023; al = 10'd1023; end
        2: begin ga = 3'd5; bb = 10'd333;  al = 10'd77;   end
        default: begin ga = 3'd0; bb = 10'd0; al = 10'd0; end
      endcase
      for (int sel = 0; sel < 64; sel++) begin
        apply(ga, bb, al, sel[5:2], sel[1:0]);
        check((sel[1:0] == 2'd1 || sel[1:0] == 2'd2) ? "R5" : "R4",
              model(13'(ga) * 13'(bb), 13'(al), sel[5:2], sel[1:0]));
      end
    end

    // R7 wrap: P+Q+1 at 7161+1023+1 stays below 2^13; P+P at max wraps
    apply(3'd7, 10'd1023, 10'd1023, 4'd9, 2'd2);
    check("R7", 13'd8185);
    apply(3'd6, 10'd1000, 10'd0, 4'd12, 2'd1);
    check("R7", 13'd3808);

    // R1: product extremes through the pass-P row
    apply(3'd4, 10'd512, 10'd5, 4'd15, 2'd0);
    check("R1", 13'd2048);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule